// File: doc/BRIEF.md
# Reversible Carry-Lookahead Adder

This block adds two n-bit operands and a carry-in. Every step of the adder is a reversible control gate. A control gate XORs a function of some lines, the controlling lines, into other lines, the controlled lines, and leaves the controlling lines untouched. Three such stages run in sequence:

- The first stage forms generate and propagate bits.
- The second stage forms every carry at once from the generate bits, the propagate bits and the carry-in. Each carry is fully expanded back to the carry-in, so the stage is a single gate.
- The third stage turns the propagate bits into sum bits.

Inversions cost nothing, so the logic depth stays at three for any width.

The block works on a bundle of 4n+1 lines, which is 17 lines for n = 4. The bundle carries the addend, the augend, the carry-in and 2n constant lines. The constant lines are expected to be zero on entry. The output bundle has the same width. It holds the addend and carry-in unchanged, the sum in place of the augend, the generate bits on the first n constant lines, and the carries C1..Cn on the last n.

A direction input selects whether the three stages are applied forward or undone. Undoing them runs the stage inverses in the opposite order, so feeding a forward result back in restores the original bundle. One output register captures the result when `inValid` is high. A flag reports constant lines that are not zero.

Line layout, from bit 0 upward:

| Field | Bits | Forward output |
|---|---|---|
| A | [n-1:0] | A, unchanged |
| B | [2n-1:n] | sum |
| C0 | [2n] | carry-in, unchanged |
| G | [3n:2n+1] | generate bits |
| K | [4n:3n+1] | carries; bit 3n+i holds C_i |

Top module: `rev_cla_adder`

## Requirements
- R1: In forward mode with zero constant lines, `{carryOut, sumOut}` equals A + B + C0 as an n+1-bit number. The sum sits on lines [2n-1:n] and the carry-out on line 4n.
- R2: In forward mode the A field and the C0 line of `lineOut` equal those of the captured input, whatever the constant lines hold.
- R3: In forward mode with zero constant lines, line 2n+1+i holds A_i AND B_i, and line 3n+i holds C_i, the carry into bit i, for i = 1..n.
- R4: In inverse mode, an input equal to the forward result of (A, B, C0, zero constants) yields exactly (A, B, C0, zero constants).
- R5: In forward mode, `presetErr` is 1 exactly when any captured line in [4n:2n+1] is nonzero.
- R6: In inverse mode, `presetErr` is 1 exactly when the restored lines [4n:2n+1] are nonzero.
- R7: `outValid` is `inValid` delayed by one clock. `lineOut` and `presetErr` change only on an edge where `inValid` is 1.
- R8: While `rstN` is low, `outValid`, `presetErr` and `lineOut` are 0.
- R9: Forward followed by inverse returns the original bundle exactly, even with nonzero constant lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Capture the bundle on this edge |
| inverse | input | 1 | 0 selects the forward stages, 1 selects the undo stages |
| lineIn | input | 4n+1 | Input line bundle |
| outValid | output | 1 | `lineOut` was captured on the previous edge |
| lineOut | output | 4n+1 | Output line bundle |
| sumOut | output | n | Sum view, lines [2n-1:n] |
| carryOut | output | 1 | Carry-out view, line 4n |
| presetErr | output | 1 | Constant lines nonzero (see R5, R6) |

## Verification
All 512 combinations of A, B and C0 for n = 4 run forward with zero constant lines. This covers every carry chain, including full propagation from C0 to the carry-out and the all-ones and all-zeros operands. Each forward result is then fed back inverted. This separates a stage applied in the wrong order, which would break the round trip, from an error in an arithmetic term, which would break the sum.

Random bundles with dirty constant lines run forward and then inverse. These tell apart a design that is truly a bijection from one that only works on clean inputs, and they exercise both error flags. Idle cycles between results check that the output holds.

// File: rtl/rev_cla_pkg.sv
package rev_cla_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load the output register on this edge
    logic inverse;   // select the undo chain
  } ctrlStrobe_t;
endpackage

// File: rtl/rev_cla_gp_stage.sv
// Generate/propagate control gate pair: G ^= A&B, B ^= A.
// REVERSE applies the two simple gates in the opposite order (its inverse).
module rev_cla_gp_stage #(
  parameter int N = 4,
  parameter bit REVERSE = 1'b0,
  localparam int LINES = 4 * N + 1
) (
  input  logic [LINES-1:0] linesIn,
  output logic [LINES-1:0] linesOut
);
  localparam int B_LO = N;
  localparam int G_LO = 2 * N + 1;

  logic [N-1:0] opA, opB, genIn, newB, newG;

  assign opA   = linesIn[N-1:0];
  assign opB   = linesIn[B_LO +: N];
  assign genIn = linesIn[G_LO +: N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (!REVERSE) begin : g_fwd
        // generate uses the original B, then B becomes A^B
        assign newG[i] = genIn[i] ^ (opA[i] & opB[i]);
        assign newB[i] = opB[i] ^ opA[i];
      end else begin : g_rev
        // first restore B, then clear generate with the restored B
        assign newB[i] = opB[i] ^ opA[i];
        assign newG[i] = genIn[i] ^ (opA[i] & newB[i]);
      end
    end
  endgenerate

  always_comb begin
    linesOut = linesIn;
    linesOut[B_LO +: N] = newB;
    linesOut[G_LO +: N] = newG;
  end
endmodule

// File: rtl/rev_cla_carry_stage.sv
// One control gate: 2N+1 controlling lines (G, P, C0) set N carry lines.
// Self-inverse since the controlling lines pass unchanged.
module rev_cla_carry_stage #(
  parameter int N = 4,
  localparam int LINES = 4 * N + 1
) (
  input  logic [LINES-1:0] linesIn,
  output logic [LINES-1:0] linesOut
);
  localparam int B_LO  = N;
  localparam int C0_AT = 2 * N;
  localparam int G_LO  = 2 * N + 1;
  localparam int K_LO  = 3 * N + 1;

  logic [N-1:0] genBits, propBits, carryFn;
  logic carryIn;

  assign genBits  = linesIn[G_LO +: N];
  assign propBits = linesIn[B_LO +: N];
  assign carryIn  = linesIn[C0_AT];

  // carry i+1 = G_i | P_i & (carry i), expanded down to C0
  generate
    for (genvar i = 0; i < N; i++) begin : g_carry
      logic [i+1:0] term;
      assign term[0] = carryIn;
      for (genvar j = 0; j <= i; j++) begin : g_term
        assign term[j+1] = genBits[j] | (propBits[j] & term[j]);
      end
      assign carryFn[i] = term[i+1];
    end
  endgenerate

  always_comb begin
    linesOut = linesIn;
    linesOut[K_LO +: N] = linesIn[K_LO +: N] ^ carryFn;
  end
endmodule

// File: rtl/rev_cla_sum_stage.sv
// Sum control gate: S_i = P_i ^ C_i, with C_0 from the carry-in line.
// Self-inverse.
module rev_cla_sum_stage #(
  parameter int N = 4,
  localparam int LINES = 4 * N + 1
) (
  input  logic [LINES-1:0] linesIn,
  output logic [LINES-1:0] linesOut
);
  localparam int B_LO  = N;
  localparam int C0_AT = 2 * N;
  localparam int K_LO  = 3 * N + 1;

  logic [N-1:0] carryInto, newB;

  generate
    for (genvar i = 0; i < N; i++) begin : g_sum
      if (i == 0) begin : g_first
        assign carryInto[i] = linesIn[C0_AT];
      end else begin : g_rest
        assign carryInto[i] = linesIn[K_LO + i - 1];
      end
      assign newB[i] = linesIn[B_LO + i] ^ carryInto[i];
    end
  endgenerate

  always_comb begin
    linesOut = linesIn;
    linesOut[B_LO +: N] = newB;
  end
endmodule

// File: rtl/rev_cla_datapath.sv
module rev_cla_datapath
  import rev_cla_pkg::*;
#(
  parameter int N = 4,
  localparam int LINES = 4 * N + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [LINES-1:0] lineIn,
  output logic [LINES-1:0] lineOut,
  output logic             presetErr
);
  localparam int G_LO = 2 * N + 1;

  logic [LINES-1:0] fwdGp, fwdCarry, fwdSum;
  logic [LINES-1:0] invSum, invCarry, invGp;
  logic [LINES-1:0] nextLines;
  logic             nextErr;

  // forward chain
  rev_cla_gp_stage    #(.N(N), .REVERSE(1'b0)) u_fGp    (.linesIn(lineIn),   .linesOut(fwdGp));
  rev_cla_carry_stage #(.N(N))                 u_fCarry (.linesIn(fwdGp),    .linesOut(fwdCarry));
  rev_cla_sum_stage   #(.N(N))                 u_fSum   (.linesIn(fwdCarry), .linesOut(fwdSum));

  // undo chain, stages in opposite order
  rev_cla_sum_stage   #(.N(N))                 u_iSum   (.linesIn(lineIn),   .linesOut(invSum));
  rev_cla_carry_stage #(.N(N))                 u_iCarry (.linesIn(invSum),   .linesOut(invCarry));
  rev_cla_gp_stage    #(.N(N), .REVERSE(1'b1)) u_iGp    (.linesIn(invCarry), .linesOut(invGp));

  always_comb begin
    if (strobe.inverse) begin
      nextLines = invGp;
      nextErr   = |invGp[LINES-1:G_LO];
    end else begin
      nextLines = fwdSum;
      nextErr   = |lineIn[LINES-1:G_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineOut   <= '0;
      presetErr <= 1'b0;
    end else if (strobe.capture) begin
      lineOut   <= nextLines;
      presetErr <= nextErr;
    end
  end
endmodule

// File: rtl/rev_cla_control.sv
module rev_cla_control
  import rev_cla_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inverse,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.capture = inValid;
    strobe.inverse = inverse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/rev_cla_adder.sv
module rev_cla_adder
  import rev_cla_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inverse,
  input  logic [4*N:0] lineIn,
  output logic         outValid,
  output logic [4*N:0] lineOut,
  output logic [N-1:0] sumOut,
  output logic         carryOut,
  output logic         presetErr
);
  ctrlStrobe_t strobe;

  rev_cla_control u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inverse(inverse),
    .strobe(strobe), .outValid(outValid)
  );

  rev_cla_datapath #(.N(N)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineIn(lineIn),
    .lineOut(lineOut), .presetErr(presetErr)
  );

  assign sumOut   = lineOut[2*N-1:N];
  assign carryOut = lineOut[4*N];
endmodule

// File: rtl/rev_cla_adder_chk.sv
module rev_cla_adder_chk #(
  parameter int N = 4,
  localparam int LINES = 4 * N + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inverse,
  input logic [LINES-1:0] lineIn,
  input logic             outValid,
  input logic [LINES-1:0] lineOut,
  input logic [N-1:0]     sumOut,
  input logic             carryOut,
  input logic             presetErr
);
  localparam int G_LO = 2 * N + 1;

  function automatic logic [N:0] refSum(input logic [LINES-1:0] l);
    return {1'b0, l[N-1:0]} + {1'b0, l[2*N-1:N]} + {{N{1'b0}}, l[2*N]};
  endfunction

  // R1
  sum_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inverse && lineIn[LINES-1:G_LO] == '0)
      |=> ({carryOut, sumOut} == refSum($past(lineIn))));

  // R2
  operand_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inverse)
      |=> (lineOut[N-1:0] == $past(lineIn[N-1:0]) && lineOut[2*N] == $past(lineIn[2*N])));

  // R5
  preset_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inverse) |=> (presetErr == ($past(lineIn[LINES-1:G_LO]) != '0)));

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R7
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(lineOut) && $stable(presetErr)));
endmodule

bind rev_cla_adder rev_cla_adder_chk #(.N(N)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inverse(inverse),
  .lineIn(lineIn), .outValid(outValid), .lineOut(lineOut),
  .sumOut(sumOut), .carryOut(carryOut), .presetErr(presetErr)
);

// File: tb/sim_rev_cla_adder.sv
`timescale 1ns/1ps
module sim_rev_cla_adder;
  localparam int N = 4;
  localparam int LINES = 4 * N + 1;
  localparam int G_LO = 2 * N + 1;
  localparam int K_LO = 3 * N + 1;

  // item kinds
  localparam int K_FWD   = 0;  // forward, clean constants
  localparam int K_INV   = 1;  // inverse of a clean forward image
  localparam int K_DIRTY = 2;  // forward, dirty constants
  localparam int K_BACK  = 3;  // inverse of a dirty forward image

  typedef struct {
    int               kind;
    logic [LINES-1:0] stim;
    logic [LINES-1:0] line;
    logic             err;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inverse = 1'b0;
  logic [LINES-1:0] lineIn = '0;
  logic outValid;
  logic [LINES-1:0] lineOut;
  logic [N-1:0] sumOut;
  logic carryOut;
  logic presetErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #2.5 clk = ~clk;

  rev_cla_adder #(.N(N)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inverse(inverse),
    .lineIn(lineIn), .outValid(outValid), .lineOut(lineOut),
    .sumOut(sumOut), .carryOut(carryOut), .presetErr(presetErr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Forward image with clean constants, from arithmetic alone
  function automatic logic [LINES-1:0] fwdModel(input logic [N-1:0] a, input logic [N-1:0] b, input logic c0);
    logic [LINES-1:0] l;
    logic [N:0] s;
    l = '0;
    s = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, c0};
    l[N-1:0] = a;
    l[2*N-1:N] = s[N-1:0];
    l[2*N] = c0;
    l[G_LO +: N] = a & b;
    for (int i = 1; i <= N; i++) begin
      logic [N:0] part;
      logic [N:0] mask;
      mask = ({{N{1'b0}}, 1'b1} << i) - 1'b1;
      part = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{N{1'b0}}, c0};
      l[K_LO + i - 1] = part[i];
    end
    return l;
  endfunction

  task automatic sendVec(input logic [LINES-1:0] stim, input logic inv, input int kind,
                         input logic [LINES-1:0] expLine, input logic expErr);
    item_t it;
    @(negedge clk);
    inValid = 1'b1;
    inverse = inv;
    lineIn  = stim;
    it.kind = kind; it.stim = stim; it.line = expLine; it.err = expErr;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      lineIn  = '0;
    end
  endtask

  // Monitor: pops and compares each result, checks holding on idle cycles
  initial begin
    logic [LINES-1:0] prevLine;
    logic prevErr;
    prevLine = '0;
    prevErr = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (rstN) begin
        if (outValid) begin
          item_t it;
          if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected outValid", 64'(outValid), 64'd0);
          end else begin
            it = sb.pop_front();
            case (it.kind)
              K_FWD: begin
                check({carryOut, sumOut} == {it.line[4*N], it.line[2*N-1:N]}, "R1 sum/carry",
                      64'({carryOut, sumOut}), 64'({it.line[4*N], it.line[2*N-1:N]}));
                check(lineOut[N-1:0] == it.stim[N-1:0] && lineOut[2*N] == it.stim[2*N], "R2 operands",
                      64'(lineOut), 64'(it.stim));
                check(lineOut[LINES-1:G_LO] == it.line[LINES-1:G_LO], "R3 generate/carry lines",
                      64'(lineOut[LINES-1:G_LO]), 64'(it.line[LINES-1:G_LO]));
                check(presetErr == 1'b0, "R5 clean flag", 64'(presetErr), 64'd0);
              end
              K_INV: begin
                check(lineOut == it.line, "R4 restore", 64'(lineOut), 64'(it.line));
                check(presetErr == 1'b0, "R6 clean restore flag", 64'(presetErr), 64'd0);
              end
              K_DIRTY: begin
                check(lineOut[N-1:0] == it.stim[N-1:0] && lineOut[2*N] == it.stim[2*N], "R2 operands dirty",
                      64'(lineOut), 64'(it.stim));
                check(presetErr == it.err, "R5 dirty flag", 64'(presetErr), 64'(it.err));
              end
              default: begin
                check(lineOut == it.line, "R9 round trip", 64'(lineOut), 64'(it.line));
                check(presetErr == it.err, "R6 dirty restore flag", 64'(presetErr), 64'(it.err));
              end
            endcase
          end
        end else begin
          check(lineOut == prevLine && presetErr == prevErr, "R7 hold",
                64'(lineOut), 64'(prevLine));
        end
      end
      prevLine = lineOut;
      prevErr  = presetErr;
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Driver
  initial begin
    logic [LINES-1:0] snap;
    // R8 reset state, with inputs active
    repeat (3) @(negedge clk);
    inValid = 1'b1;
    lineIn = '1;
    @(negedge clk);
    #1;
    check(outValid == 1'b0 && presetErr == 1'b0 && lineOut == '0, "R8 reset",
          64'({outValid, presetErr, lineOut}), 64'd0);
    @(negedge clk);
    inValid = 1'b0;
    lineIn = '0;
    rstN = 1'b1;
    idle(2);

    // R1 R2 R3 R5: exhaustive forward, clean constants; R4: each image undone
    for (int v = 0; v < (1 << (2 * N + 1)); v++) begin
      logic [N-1:0] a, b;
      logic c0;
      logic [LINES-1:0] orig, img;
      a = v[N-1:0];
      b = v[2*N-1:N];
      c0 = v[2*N];
      orig = '0;
      orig[N-1:0] = a; orig[2*N-1:N] = b; orig[2*N] = c0;
      img = fwdModel(a, b, c0);
      sendVec(orig, 1'b0, K_FWD, img, 1'b0);
      sendVec(img, 1'b1, K_INV, orig, 1'b0);
      if (v % 64 == 0) idle(2);
    end
    idle(3);

    // R9 R5 R6: dirty constants, forward then back
    for (int t = 0; t < 40; t++) begin
      logic [LINES-1:0] orig;
      orig = LINES'({$urandom, $urandom});
      if (t == 0) orig[LINES-1:G_LO] = '1;
      if (t == 1) orig[LINES-1:G_LO] = {{(2*N-1){1'b0}}, 1'b1};
      if (t == 2) orig[LINES-1:G_LO] = '0;
      sendVec(orig, 1'b0, K_DIRTY, '0, orig[LINES-1:G_LO] != '0);
      @(negedge clk);
      inValid = 1'b0;
      #2;
      snap = lineOut;
      sendVec(snap, 1'b1, K_BACK, orig, orig[LINES-1:G_LO] != '0);
      idle(1);
    end
    idle(4);
    check(sb.size() == 0, "R7 all results seen", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule